// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides which interrupt a small 8-bit core serves next. Five maskable sources, indexed 0 to 4, and one non-maskable software trap each feed an internal pending latch. Each maskable source carries a two-bit software level. The arbiter compares these levels with the level of the code that is running. When two sources share a level, a fixed hardware order breaks the tie, and source 0 ranks highest. The block presents one winner to the core. It keeps the running level and a short stack of the levels saved on each handler entry, and it restores them on handler return.

A mode input selects one of two policies. In nested mode, a higher-level source may interrupt a running handler. In concurrent mode, nothing maskable is offered until all handlers have returned. During the Wait low-power state, any eligible source raises the wake output. During Halt, only sources marked halt-capable raise it. After a wake from Halt, the first source served is the best halt-capable one. A per-source clear strobe models the peripheral's status clear sequence and drops a pending request that has not been served.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, no request is pending, `cur_lvl_o` is 0 and `irq_o` and `wake_o` are low. A `req_i` bit that is high at a clock edge sets that source's pending latch, and the latch holds until the source is served or cleared.
- R2: A `clr_i` bit high at a clock edge clears that source's latch, and it wins over a `req_i` bit on the same source in the same cycle. A pending request cleared this way is never presented.
- R3: A maskable source is eligible when it is pending and its level field (bits 2i+1:2i of `lvl_i`) is strictly greater than `cur_lvl_o`. The eligible source with the highest level wins. On a tie, the lowest index wins. `vec_o` gives the source index (0 to 4) and gives 5 for the trap.
- R4: A pending trap is always presented ahead of every maskable source, whatever the current level or mode. Serving the trap sets the current level to 3.
- R5: When `ack_i` is high while `irq_o` is high and `ret_i` is low, the current level is pushed on the stack and replaced by the winner's level (3 for the trap). The winner's latch clears at the same edge.
- R6: `ret_i` pops the most recently saved level into `cur_lvl_o`. A `ret_i` with an empty stack leaves the level unchanged. If `ret_i` and `ack_i` are high together, the return is taken and the acknowledge is ignored.
- R7: In nested mode (`nested_i` = 1), an eligible source is presented while a handler is running.
- R8: In concurrent mode (`nested_i` = 0), no maskable source is presented while any saved level is on the stack. A pending trap is still presented.
- R9: The stack holds 4 levels. A fifth push overwrites the oldest entry without any indication, so only the four newest levels come back on return.
- R10: While `wait_i` or `halt_i` is high, `irq_o` is low. In Wait, `wake_o` is high when any source is eligible.
- R11: In Halt (`halt_i` wins over `wait_i`), `wake_o` rises only for an eligible source whose `halt_cap_i` bit is set, or for a pending trap.
- R12: Once Halt has produced a wake, only halt-capable sources (and the trap) may be presented until the next acknowledge. After that acknowledge, the normal choice applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 5 | Per-source request, sets the pending latch |
| clr_i | input | 5 | Per-source clear-sequence strobe |
| trap_i | input | 1 | Software trap request |
| lvl_i | input | 10 | Two-bit software level per source, source i at bits 2i+1:2i |
| halt_cap_i | input | 5 | Per-source halt-capable mark |
| nested_i | input | 1 | 1 = nested mode, 0 = concurrent mode |
| ack_i | input | 1 | Core takes the presented interrupt |
| ret_i | input | 1 | Core returns from a handler |
| wait_i | input | 1 | Core is in Wait |
| halt_i | input | 1 | Core is in Halt |
| irq_o | output | 1 | An interrupt is presented |
| vec_o | output | 3 | Index of the presented source, 5 = trap |
| wake_o | output | 1 | Wake the core from its low-power state |
| cur_lvl_o | output | 2 | Level of the running context |

## Verification
A corrupted pending latch shows at the ports on the next cycle, either as a spurious `irq_o` or as a wrong `vec_o`. A bad level or a bad stack entry stays hidden until a return or a compare against some source. The overflow case has to run five nests and five returns before a wrong oldest-entry policy appears on `cur_lvl_o`. The Halt restriction flag shows only in the first `vec_o` after Halt ends, so the checks compare every cycle against a model rather than only at the end of each sequence.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] srv_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_d;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign pend_d[g] = (pend_q[g] | set_i[g]) & ~clr_i[g] & ~srv_i[g];

      // R2
      clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[g] |=> !pend_o[g]);

      // R1
      set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[g] && !clr_i[g] && !srv_i[g]) |=> pend_o[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned VEC_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC:0]         pend_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  input  logic [NSRC-1:0]       cap_i,
  input  lvl_t                  cur_lvl_i,
  input  logic                  allow_i,
  input  logic                  halt_only_i,
  output logic                  valid_o,
  output logic [VEC_W-1:0]      vec_o,
  output lvl_t                  lvl_o
);
  localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(NSRC);

  logic             found;
  lvl_t             best;
  logic [VEC_W-1:0] bidx;
  lvl_t             src_lvl;
  logic             elig;

  always_comb begin
    found   = 1'b0;
    best    = '0;
    bidx    = '0;
    src_lvl = '0;
    elig    = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      src_lvl = lvl_i[i*LVL_W +: LVL_W];
      elig    = pend_i[i] && allow_i && (src_lvl > cur_lvl_i) &&
                (!halt_only_i || cap_i[i]);
      if (elig && (!found || (src_lvl >= best))) begin
        found = 1'b1;
        best  = src_lvl;
        bidx  = VEC_W'(i);
      end
    end
    if (pend_i[NSRC]) begin
      found = 1'b1;
      best  = LVL_TOP;
      bidx  = TRAP_VEC;
    end
  end

  assign valid_o = found;
  assign vec_o   = bidx;
  assign lvl_o   = best;

  // R4
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[NSRC] |-> (valid_o && vec_o == TRAP_VEC));

  // R3
  winner_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && vec_o != TRAP_VEC) |-> (pend_i[vec_o] && lvl_o > cur_lvl_i));
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  lvl_t                       push_lvl_i,
  input  logic                       pop_i,
  output lvl_t                       cur_lvl_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);
  localparam int unsigned DPW = $clog2(DEPTH + 1);
  localparam int unsigned PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0]  WP_LAST = PW'(DEPTH - 1);
  localparam logic [DPW-1:0] D_FULL  = DPW'(DEPTH);

  lvl_t           stk_q [DEPTH];
  logic [PW-1:0]  wp_q, wp_d;
  logic [DPW-1:0] depth_q, depth_d;
  lvl_t           cur_q, cur_d;
  logic           wr_en;
  logic           ctx_en;

  always_comb begin
    wp_d    = wp_q;
    depth_d = depth_q;
    cur_d   = cur_q;
    wr_en   = 1'b0;
    if (pop_i && depth_q != '0) begin
      wp_d    = (wp_q == '0) ? WP_LAST : wp_q - 1'b1;
      depth_d = depth_q - 1'b1;
      cur_d   = stk_q[wp_d];
    end else if (push_i) begin
      wr_en   = 1'b1;
      wp_d    = (wp_q == WP_LAST) ? '0 : wp_q + 1'b1;
      depth_d = (depth_q == D_FULL) ? depth_q : depth_q + 1'b1;
      cur_d   = push_lvl_i;
    end
  end

  assign ctx_en = (pop_i && depth_q != '0) || push_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      depth_q <= '0;
      cur_q   <= '0;
    end else if (ctx_en) begin
      wp_q    <= wp_d;
      depth_q <= depth_d;
      cur_q   <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (wr_en) begin
      stk_q[wp_q] <= cur_q;
    end
  end

  assign cur_lvl_o = cur_q;
  assign depth_o   = depth_q;

  // R9
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= D_FULL);

  // R9
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o == D_FULL) |=> depth_o == D_FULL);

  // R6
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth_o == '0 && !push_i) |=> $stable(cur_lvl_o));

  // R5
  load_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> cur_lvl_o == $past(push_lvl_i));
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned VEC_W = $clog2(NSRC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       req_i,
  input  logic [NSRC-1:0]       clr_i,
  input  logic                  trap_i,
  input  logic [NSRC*LVL_W-1:0] lvl_i,
  input  logic [NSRC-1:0]       halt_cap_i,
  input  logic                  nested_i,
  input  logic                  ack_i,
  input  logic                  ret_i,
  input  logic                  wait_i,
  input  logic                  halt_i,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  wake_o,
  output logic [LVL_W-1:0]      cur_lvl_o
);
  localparam int unsigned DPW = $clog2(DEPTH + 1);
  localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(NSRC);

  logic [1:0]      rst_sync_q;
  logic            rst_n_int;
  logic [NSRC:0]   pend;
  logic [NSRC:0]   srv;
  logic            sel_valid;
  logic [VEC_W-1:0] sel_vec;
  lvl_t            sel_lvl;
  lvl_t            cur_lvl;
  logic [DPW-1:0]  depth;
  logic            allow;
  logic            halt_only;
  logic            low_pwr;
  logic            do_ack;
  logic            ph_q, ph_d, ph_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    srv = '0;
    if (do_ack) srv[sel_vec] = 1'b1;
  end

  irq_pend_latch #(.NCH(NSRC + 1)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_i  ({trap_i, req_i}),
    .clr_i  ({1'b0, clr_i}),
    .srv_i  (srv),
    .pend_o (pend)
  );

  assign allow     = nested_i || (depth == '0);
  assign halt_only = halt_i || ph_q;

  irq_prio_sel #(.NSRC(NSRC), .VEC_W(VEC_W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .pend_i      (pend),
    .lvl_i       (lvl_i),
    .cap_i       (halt_cap_i),
    .cur_lvl_i   (cur_lvl),
    .allow_i     (allow),
    .halt_only_i (halt_only),
    .valid_o     (sel_valid),
    .vec_o       (sel_vec),
    .lvl_o       (sel_lvl)
  );

  assign low_pwr = wait_i || halt_i;
  assign irq_o   = sel_valid && !low_pwr;
  assign wake_o  = sel_valid && low_pwr;
  assign vec_o   = sel_vec;
  assign do_ack  = irq_o && ack_i && !ret_i;

  irq_lvl_stack #(.DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .push_i     (do_ack),
    .push_lvl_i (sel_lvl),
    .pop_i      (ret_i),
    .cur_lvl_o  (cur_lvl),
    .depth_o    (depth)
  );
  assign cur_lvl_o = cur_lvl;

  always_comb begin
    ph_en = (halt_i && wake_o) || do_ack;
    ph_d  = halt_i && wake_o;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ph_q <= 1'b0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  // R10
  irq_lp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    low_pwr |-> !irq_o);

  // R8
  conc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!nested_i && depth != '0 && irq_o) |-> vec_o == TRAP_VEC);

  // R11
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (halt_i && wake_o && vec_o != TRAP_VEC) |-> halt_cap_i[vec_o]);

  // R12
  post_halt_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ph_q && irq_o && vec_o != TRAP_VEC) |-> halt_cap_i[vec_o]);

  // R5
  served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    do_ack |=> !pend[$past(vec_o)]);
endmodule

// File: tb/tb_irq_arb_top.sv
`timescale 1ns/1ps
module tb_irq_arb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] req_i, clr_i, halt_cap_i;
  logic       trap_i, nested_i, ack_i, ret_i, wait_i, halt_i;
  logic [9:0] lvl_i;
  logic       irq_o, wake_o;
  logic [2:0] vec_o;
  logic [1:0] cur_lvl_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [5:0] m_pend;
  logic [1:0] m_cur;
  logic [1:0] m_stk [4];
  int         m_wp, m_depth;
  logic       m_ph;

  always #4 clk = ~clk;

  irq_arb_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i), .trap_i(trap_i),
    .lvl_i(lvl_i), .halt_cap_i(halt_cap_i), .nested_i(nested_i),
    .ack_i(ack_i), .ret_i(ret_i), .wait_i(wait_i), .halt_i(halt_i),
    .irq_o(irq_o), .vec_o(vec_o), .wake_o(wake_o), .cur_lvl_o(cur_lvl_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void msel(output logic v, output logic [2:0] vec,
                               output logic [1:0] l);
    logic [1:0] sl;
    v = 1'b0; vec = '0; l = '0;
    if (m_pend[5]) begin
      v = 1'b1; vec = 3'd5; l = 2'd3;
    end else if (nested_i || m_depth == 0) begin
      for (int i = 0; i < 5; i++) begin
        sl = lvl_i[2*i +: 2];
        if (m_pend[i] && sl > m_cur && (!(halt_i || m_ph) || halt_cap_i[i]) &&
            (!v || sl > l)) begin
          v = 1'b1; vec = 3'(i); l = sl;
        end
      end
    end
  endfunction

  task automatic mreset();
    m_pend = '0; m_cur = '0; m_wp = 0; m_depth = 0; m_ph = 1'b0;
    for (int i = 0; i < 4; i++) m_stk[i] = '0;
  endtask

  task automatic mupdate();
    logic v, lp, ack, wk;
    logic [2:0] vec;
    logic [1:0] l;
    logic [5:0] srv;
    msel(v, vec, l);
    lp  = wait_i || halt_i;
    ack = v && !lp && ack_i && !ret_i;
    wk  = v && lp;
    srv = '0;
    if (ack) srv[vec] = 1'b1;
    if (halt_i && wk) m_ph = 1'b1;
    else if (ack) m_ph = 1'b0;
    m_pend = (m_pend | {trap_i, req_i}) & ~{1'b0, clr_i} & ~srv;
    if (ret_i && m_depth > 0) begin
      m_wp = (m_wp + 3) % 4; m_cur = m_stk[m_wp]; m_depth--;
    end else if (ack) begin
      m_stk[m_wp] = m_cur; m_wp = (m_wp + 1) % 4;
      if (m_depth < 4) m_depth++;
      m_cur = l;
    end
  endtask

  task automatic compare();
    logic v, lp;
    logic [2:0] vec;
    logic [1:0] l;
    msel(v, vec, l);
    lp = wait_i || halt_i;
    check("R3 irq_o", int'(irq_o), int'(v && !lp));
    if (v) check("R3 vec_o", int'(vec_o), int'(vec));
    check("R10 wake_o", int'(wake_o), int'(v && lp));
    check("R5 cur_lvl_o", int'(cur_lvl_o), int'(m_cur));
  endtask

  task automatic step();
    @(posedge clk);
    mupdate();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    req_i = '0; clr_i = '0; trap_i = 1'b0; ack_i = 1'b0; ret_i = 1'b0;
  endtask

  task automatic do_reset();
    quiet();
    wait_i = 1'b0; halt_i = 1'b0; nested_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    mreset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [4:0] m);
    req_i = m; step(); req_i = '0;
  endtask
  task automatic pulse_trap();
    trap_i = 1'b1; step(); trap_i = 1'b0;
  endtask
  task automatic do_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask
  task automatic do_ret();
    ret_i = 1'b1; step(); ret_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    lvl_i = '0; halt_cap_i = '0;
    do_reset();
    // R1 reset state
    check("R1 reset irq_o", int'(irq_o), 0);
    check("R1 reset cur_lvl_o", int'(cur_lvl_o), 0);
    check("R1 reset wake_o", int'(wake_o), 0);

    lvl_i = {5{2'b01}};
    pulse_req(5'b10100);
    check("R3 tie irq_o", int'(irq_o), 1);
    check("R3 tie vec_o", int'(vec_o), 2);

    clr_i = 5'b00100; req_i = 5'b00100; step(); quiet();
    check("R2 clear wins vec_o", int'(vec_o), 4);

    do_ack();
    check("R5 level loaded", int'(cur_lvl_o), 1);
    check("R5 served latch cleared", int'(irq_o), 0);

    lvl_i[7:6] = 2'b10;
    pulse_req(5'b01000);
    check("R7 nested preempt irq_o", int'(irq_o), 1);
    check("R7 nested preempt vec_o", int'(vec_o), 3);
    nested_i = 1'b0; #1;
    check("R8 concurrent holds", int'(irq_o), 0);
    nested_i = 1'b1; #1;
    do_ack();
    check("R5 nested level", int'(cur_lvl_o), 2);
    do_ret();
    check("R6 restore", int'(cur_lvl_o), 1);
    do_ret();
    check("R6 restore main", int'(cur_lvl_o), 0);
    do_ret();
    check("R6 empty ret", int'(cur_lvl_o), 0);

    pulse_trap();
    check("R4 trap vec_o", int'(vec_o), 5);
    do_ack();
    check("R4 trap level", int'(cur_lvl_o), 3);
    nested_i = 1'b0;
    pulse_trap();
    check("R8 trap in concurrent", int'(irq_o), 1);
    check("R4 trap at level 3", int'(vec_o), 5);
    do_ack();
    do_ret(); do_ret();
    check("R6 after traps", int'(cur_lvl_o), 0);
    nested_i = 1'b1;

    // R9 overflow: pushes of 0,1,2,3,3 with the oldest overwritten
    lvl_i = 10'b00_00_11_10_01 << 4;
    lvl_i = {2'b01, 2'b10, 2'b11, 2'b00, 2'b00};
    pulse_req(5'b10000); do_ack();
    pulse_req(5'b01000); do_ack();
    pulse_req(5'b00100); do_ack();
    pulse_trap(); do_ack();
    pulse_trap(); do_ack();
    for (int k = 0; k < 5; k++) do_ret();
    check("R9 oldest overwritten", int'(cur_lvl_o), 1);

    do_reset();
    lvl_i = {5{2'b01}};
    wait_i = 1'b1;
    pulse_req(5'b00001);
    check("R10 no irq in wait", int'(irq_o), 0);
    check("R10 wake in wait", int'(wake_o), 1);
    wait_i = 1'b0; #1;
    check("R1 pending kept", int'(irq_o), 1);
    do_ack(); do_ret();

    lvl_i = {2'b01, 2'b01, 2'b01, 2'b01, 2'b11};
    halt_cap_i = 5'b00010;
    halt_i = 1'b1;
    pulse_req(5'b00001);
    check("R11 non-capable no wake", int'(wake_o), 0);
    pulse_req(5'b00010);
    check("R11 capable wakes", int'(wake_o), 1);
    step();
    halt_i = 1'b0; #1;
    check("R12 first after halt", int'(vec_o), 1);
    do_ack();
    check("R12 then normal", int'(vec_o), 0);
    do_ack(); do_ret(); do_ret();

    // random phase
    do_reset();
    void'($urandom(32'h5EED));
    for (int c = 0; c < 6000; c++) begin
      if (c % 50 == 0) begin
        lvl_i = 10'($urandom); halt_cap_i = 5'($urandom);
      end
      if (c % 200 == 0) nested_i = 1'($urandom);
      if (c % 8 == 0) begin
        int s = int'($urandom % 16);
        wait_i = (s == 0); halt_i = (s == 1);
      end
      req_i  = 5'($urandom) & 5'($urandom) & 5'($urandom);
      clr_i  = 5'($urandom) & 5'($urandom) & 5'($urandom) & 5'($urandom);
      trap_i = ($urandom % 40 == 0);
      ack_i  = 1'($urandom);
      ret_i  = !ack_i && ($urandom % 6 == 0);
      step();
    end
    quiet();
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule